// File: doc/BRIEF.md
# Programmable Serial Byte Transmitter

This block sends bytes as asynchronous serial frames on a single output line. A host reaches it through a small byte-wide register port with an address, write data, a write strobe and combinational read data. Through that port the host sets the framing, which covers word length, parity and stop period. It also sets a 16-bit clock divisor and writes the bytes to send. The divisor turns the input clock into an oversampling tick at sixteen times the bit rate, and every bit lasts sixteen of those ticks.

The two divisor bytes share addresses with the data register and the interrupt-enable register. A bank-select bit in the line control register decides which of the two a write reaches. A single holding register lets the host queue one byte while a frame is on the line. That byte goes out straight after the current stop period ends. The framing is captured when each frame starts. The divisor acts on the tick as soon as it is written.

Top module: `uart_tx_core`

## Requirements
- R1: After reset the line is high. The status register at address 5 reads 0x60: bit 5 shows the holding register empty and bit 6 shows the transmitter empty.
- R2: With line control bit 7 set, a write to address 0 sets the divisor low byte and a write to address 1 sets the divisor high byte. Both bytes read back at those addresses. Such writes start no frame and leave the interrupt-enable register unchanged.
- R3: For a divisor D of 1 or more, the oversampling tick occurs once every D clocks. Each bit lasts 16 ticks, or 16*D clocks.
- R4: A frame is a low start bit followed by the data bits, least significant bit first. Line control bits [1:0] give the word length: 00 selects 5 bits, 01 selects 6, 10 selects 7 and 11 selects 8.
- R5: Line control bit 3 adds a parity bit after the data. Line control bit 4 set selects even parity, so the data and parity together hold an even number of ones. Bit 4 clear selects odd parity.
- R6: The stop period is high. It lasts 16 ticks when line control bit 2 is clear. With bit 2 set it lasts 24 ticks for a 5-bit word and 32 ticks for any other word length.
- R7: With line control bit 7 clear, a write to address 0 loads the holding register and clears status bit 5 until the frame logic takes the byte. A byte written during a frame starts in the cycle after that frame's stop period ends, with no idle time between the frames.
- R8: While the divisor is zero no tick occurs and no frame starts. The line stays high and a written byte stays held.
- R9: The framing fields are captured when a frame starts, so a line control write during a frame applies from the next frame on. A divisor change takes effect on the tick right away.
- R10: With line control bit 7 clear, address 1 reads and writes the interrupt-enable register. Address 3 reads back the line control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe, one write per cycle |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| txd_o | output | 1 | Serial output line |

## Verification
The line and the status register are compared every cycle against a behavioural model that expands each frame into a list of level and duration segments. Bytes with mixed bit patterns, sent at every word length, tell bit order and word length apart. Sending both parity senses with data of odd and even weight separates even parity from odd. Sending the short, one-and-a-half and double stop periods, and running at divisor 3 beside divisor 1, exposes tick or stop-length miscounts. Three further cases each target one property: a byte written in mid-frame checks gapless chaining, line control and divisor writes in mid-frame check when new settings take effect, and a byte written while the divisor is zero checks that the line stays idle.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam logic [2:0] ADDR_DATA = 3'd0;
  localparam logic [2:0] ADDR_IEN  = 3'd1;
  localparam logic [2:0] ADDR_LCTL = 3'd3;
  localparam logic [2:0] ADDR_STAT = 3'd5;

  localparam int LC_LONG_STOP = 2;
  localparam int LC_PAR_EN    = 3;
  localparam int LC_PAR_EVEN  = 4;
  localparam int LC_BANK      = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PARITY, ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       long_stop;
    logic       par_en;
    logic       par_even;
  } frame_cfg_t;
endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  // >= keeps the count bounded when the divisor drops below it
  assign tick_o = (div_i != '0) && (cnt_q >= div_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (div_i == '0 || tick_o)     cnt_q <= '0;
    else                                cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/uart_tx_regs.sv
module uart_tx_regs
  import uart_tx_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       addr_i,
  input  logic [7:0]       wdata_i,
  input  logic             we_i,
  input  logic             take_i,
  input  logic             busy_i,
  output logic [7:0]       rdata_o,
  output logic [7:0]       hold_o,
  output logic             hold_full_o,
  output logic             bank_o,
  output frame_cfg_t       cfg_o,
  output logic [DIV_W-1:0] div_o
);
  logic [7:0] hold_q, ien_q, lctl_q, div_lo_q, div_hi_q;
  logic       full_q;

  assign bank_o = lctl_q[LC_BANK];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q   <= '0;
      ien_q    <= '0;
      lctl_q   <= '0;
      div_lo_q <= '0;
      div_hi_q <= '0;
      full_q   <= 1'b0;
    end else begin
      if (take_i) full_q <= 1'b0;
      if (we_i) begin
        unique case (addr_i)
          ADDR_DATA: begin
            if (bank_o) div_lo_q <= wdata_i;
            else begin
              hold_q <= wdata_i;
              full_q <= 1'b1;   // write wins over take
            end
          end
          ADDR_IEN: begin
            if (bank_o) div_hi_q <= wdata_i;
            else        ien_q    <= wdata_i;
          end
          ADDR_LCTL: lctl_q <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_DATA: rdata_o = bank_o ? div_lo_q : 8'h00;
      ADDR_IEN:  rdata_o = bank_o ? div_hi_q : ien_q;
      ADDR_LCTL: rdata_o = lctl_q;
      ADDR_STAT: rdata_o = {1'b0, !full_q && !busy_i, !full_q, 5'b0};
      default:   rdata_o = 8'h00;
    endcase
  end

  assign hold_o          = hold_q;
  assign hold_full_o     = full_q;
  assign cfg_o.wlen      = lctl_q[1:0];
  assign cfg_o.long_stop = lctl_q[LC_LONG_STOP];
  assign cfg_o.par_en    = lctl_q[LC_PAR_EN];
  assign cfg_o.par_even  = lctl_q[LC_PAR_EVEN];
  assign div_o           = DIV_W'({div_hi_q, div_lo_q});
endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
  import uart_tx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       run_ok_i,
  input  logic       hold_full_i,
  input  logic [7:0] hold_i,
  input  frame_cfg_t cfg_i,
  output logic       take_o,
  output logic       busy_o,
  output logic       txd_o
);
  localparam int TCW = $clog2(2 * OVS) + 1;
  localparam logic [TCW-1:0] LEN_BIT  = TCW'(OVS);
  localparam logic [TCW-1:0] LEN_HALF = TCW'(OVS + OVS / 2);
  localparam logic [TCW-1:0] LEN_TWO  = TCW'(2 * OVS);

  tx_state_e      state_q;
  logic [TCW-1:0] tcnt_q, stop_len_q, cur_len;
  logic [7:0]     shift_q, masked;
  logic [2:0]     bidx_q, last_q;
  logic           par_q, par_en_q, bit_end, load;

  assign cur_len = (state_q == ST_STOP) ? stop_len_q : LEN_BIT;
  assign bit_end = tick_i && (tcnt_q == cur_len - 1'b1);
  assign load    = hold_full_i && run_ok_i &&
                   (state_q == ST_IDLE || (state_q == ST_STOP && bit_end));
  assign masked  = hold_i & (8'hFF >> (2'd3 - cfg_i.wlen));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      tcnt_q     <= '0;
      shift_q    <= '0;
      bidx_q     <= '0;
      last_q     <= '0;
      par_q      <= 1'b0;
      par_en_q   <= 1'b0;
      stop_len_q <= LEN_BIT;
    end else if (load) begin
      state_q    <= ST_START;
      tcnt_q     <= '0;
      shift_q    <= masked;
      bidx_q     <= '0;
      last_q     <= 3'd4 + {1'b0, cfg_i.wlen};
      par_q      <= (^masked) ^ !cfg_i.par_even;
      par_en_q   <= cfg_i.par_en;
      stop_len_q <= !cfg_i.long_stop     ? LEN_BIT :
                    (cfg_i.wlen == 2'd0) ? LEN_HALF : LEN_TWO;
    end else if (bit_end) begin
      tcnt_q <= '0;
      unique case (state_q)
        ST_START:  state_q <= ST_DATA;
        ST_DATA: begin
          shift_q <= shift_q >> 1;
          if (bidx_q == last_q) state_q <= par_en_q ? ST_PARITY : ST_STOP;
          else                  bidx_q  <= bidx_q + 1'b1;
        end
        ST_PARITY: state_q <= ST_STOP;
        ST_STOP:   state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end else if (tick_i && state_q != ST_IDLE) begin
      tcnt_q <= tcnt_q + 1'b1;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START:  txd_o = 1'b0;
      ST_DATA:   txd_o = shift_q[0];
      ST_PARITY: txd_o = par_q;
      default:   txd_o = 1'b1;
    endcase
  end

  assign take_o = load;
  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_tx_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int OVS   = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       we_i,
  output logic [7:0] rdata_o,
  output logic       txd_o
);
  logic [DIV_W-1:0] div;
  logic [7:0]       hold;
  logic             tick, busy, take, hold_full, bank;
  frame_cfg_t       cfg;

  uart_tx_regs #(.DIV_W(DIV_W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i,
    .take_i(take), .busy_i(busy), .rdata_o,
    .hold_o(hold), .hold_full_o(hold_full), .bank_o(bank),
    .cfg_o(cfg), .div_o(div)
  );

  uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk_i, .rst_ni, .div_i(div), .tick_o(tick)
  );

  uart_tx_engine #(.OVS(OVS)) u_engine (
    .clk_i, .rst_ni, .tick_i(tick), .run_ok_i(div != '0),
    .hold_full_i(hold_full), .hold_i(hold), .cfg_i(cfg),
    .take_o(take), .busy_o(busy), .txd_o
  );
endmodule

// File: rtl/uart_tx_core_chk.sv
module uart_tx_core_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       addr_i,
  input logic             we_i,
  input logic             txd_o,
  input logic             tick,
  input logic             busy,
  input logic             hold_full,
  input logic             bank,
  input logic [DIV_W-1:0] div
);
  assert_idle_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> txd_o);

  assert_tick_every_clock_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div == DIV_W'(1)) |-> tick);

  assert_start_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> !txd_o);

  assert_hold_loaded_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 3'd0 && !bank) |=> hold_full);

  assert_no_tick_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div == '0) |-> !tick);

  assert_no_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div == '0 && !busy) |=> !busy);
endmodule

bind uart_tx_core uart_tx_core_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i, .rst_ni, .addr_i, .we_i, .txd_o,
  .tick, .busy, .hold_full, .bank, .div
);

// File: tb/tb_uart_tx_core.sv
module tb_uart_tx_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = 3'd5;
  logic [7:0] wdata = 8'h00;
  logic       we = 1'b0;
  logic [7:0] rdata;
  logic       txd;

  int    n_chk = 0, n_fail = 0;
  bit    done = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  uart_tx_core dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .rdata_o(rdata), .txd_o(txd)
  );

  // behavioural model: frame as list of (level, ticks) segments
  typedef struct { bit lvl; int ticks; } seg_t;
  seg_t q[$];
  int   m_rem, m_cnt;
  int   m_div;
  bit   m_full;
  logic [7:0] m_hold, m_lc, m_ien, m_dlo, m_dhi;

  function automatic void build_frame(logic [7:0] d, logic [7:0] lc);
    int nb = 5 + int'(lc[1:0]);
    int ones = 0;
    q.push_back('{0, 16});
    for (int i = 0; i < nb; i++) begin
      q.push_back('{d[i], 16});
      ones += d[i];
    end
    if (lc[3]) q.push_back('{lc[4] ? ones % 2 : 1 - ones % 2, 16});
    q.push_back('{1, !lc[2] ? 16 : (nb == 5 ? 24 : 32)});
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_rem = 0; m_cnt = 0; m_div = 0; m_full = 0;
      m_hold = 0; m_lc = 0; m_ien = 0; m_dlo = 0; m_dhi = 0;
    end else begin
      bit tk, was_busy, ended;
      tk = (m_div != 0) && (m_cnt >= m_div - 1);
      was_busy = (q.size() != 0);
      ended = 0;
      if (was_busy && tk) begin
        m_rem--;
        if (m_rem == 0) begin
          void'(q.pop_front());
          if (q.size() == 0) ended = 1;
          else m_rem = q[0].ticks;
        end
      end
      if ((!was_busy || ended) && m_full && m_div != 0) begin
        build_frame(m_hold, m_lc);
        m_rem = q[0].ticks;
        m_full = 0;
      end
      if (m_div == 0 || tk) m_cnt = 0; else m_cnt++;
      if (we) begin
        case (addr)
          3'd0: if (m_lc[7]) m_dlo = wdata; else begin m_hold = wdata; m_full = 1; end
          3'd1: if (m_lc[7]) m_dhi = wdata; else m_ien = wdata;
          3'd3: m_lc = wdata;
          default: ;
        endcase
        m_div = {m_dhi, m_dlo};
      end
    end
  end

  function automatic logic [7:0] m_status();
    return {1'b0, !m_full && q.size() == 0, !m_full, 5'b0};
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic exp_txd;
      exp_txd = (q.size() != 0) ? q[0].lvl : 1'b1;
      n_chk++;
      if (txd !== exp_txd) begin
        n_fail++;
        $display("FAIL %s: txd=%0b expected %0b at %0t", cur_req, txd, exp_txd, $time);
      end
      if (addr == 3'd5 && !we) begin
        n_chk++;
        if (rdata !== m_status()) begin
          n_fail++;
          $display("FAIL %s: status=%02h expected %02h at %0t", cur_req, rdata, m_status(), $time);
        end
      end
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(posedge clk); #1 addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1 we = 1'b0; addr = 3'd5;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] v);
    @(posedge clk); #1 addr = a; we = 1'b0;
    #2 v = rdata;
    @(posedge clk); #1 addr = 3'd5;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (q.size() == 0 && !m_full) break;
    end
  endtask

  task automatic send(logic [7:0] d);
    wr(3'd0, d);
    wait_idle();
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1", {7'b0, txd}, 8'h01);
    rd(3'd5, v); check("R1", v, 8'h60);

    // R8: divisor zero after reset, byte must stay held
    cur_req = "R8";
    wr(3'd0, 8'h3C);
    repeat (60) @(posedge clk);
    @(negedge clk); check("R8", {7'b0, txd}, 8'h01);
    rd(3'd5, v); check("R8", v, 8'h00);

    // R2: divisor bank; nonzero divisor releases the held byte
    cur_req = "R2";
    wr(3'd3, 8'h80); wr(3'd0, 8'h02); wr(3'd1, 8'h00);
    rd(3'd0, v); check("R2", v, 8'h02);
    rd(3'd1, v); check("R2", v, 8'h00);
    wait_idle();
    wr(3'd0, 8'h01);
    rd(3'd5, v); check("R2", v, 8'h60);
    rd(3'd0, v); check("R2", v, 8'h01);

    // R10: normal bank registers
    cur_req = "R10";
    wr(3'd3, 8'h03); wr(3'd1, 8'h5A);
    rd(3'd1, v); check("R10", v, 8'h5A);
    rd(3'd3, v); check("R10", v, 8'h03);
    wr(3'd3, 8'h83);
    rd(3'd1, v); check("R2", v, 8'h00);
    wr(3'd3, 8'h03);
    rd(3'd1, v); check("R2", v, 8'h5A);

    cur_req = "R4";
    send(8'hA5); send(8'h3C);
    wr(3'd3, 8'h01); send(8'h2D);
    wr(3'd3, 8'h02); send(8'h4B);

    cur_req = "R5";
    wr(3'd3, 8'h1A); send(8'h53);
    wr(3'd3, 8'h0B); send(8'hF0);
    wr(3'd3, 8'h0B); send(8'h01);

    cur_req = "R6";
    wr(3'd3, 8'h04); send(8'h15);
    wr(3'd3, 8'h07); send(8'h81);
    wr(3'd3, 8'h0D); send(8'h2A);

    cur_req = "R3";
    wr(3'd3, 8'h83); wr(3'd0, 8'h03); wr(3'd3, 8'h03);
    send(8'h6E);
    wr(3'd3, 8'h83); wr(3'd0, 8'h01); wr(3'd3, 8'h03);

    cur_req = "R7";
    wr(3'd0, 8'h11);
    repeat (20) @(posedge clk);
    wr(3'd0, 8'h22);
    rd(3'd5, v); check("R7", v, 8'h00);
    wait_idle();

    cur_req = "R9";
    wr(3'd0, 8'h99);
    repeat (30) @(posedge clk);
    wr(3'd3, 8'h1F);
    wait_idle();
    send(8'h99);
    wr(3'd0, 8'h44);
    repeat (40) @(posedge clk);
    wr(3'd3, 8'h9F); wr(3'd0, 8'h02); wr(3'd3, 8'h1F);
    wait_idle();
    rd(3'd3, v); check("R10", v, 8'h1F);
    @(negedge clk); check("R1", {7'b0, txd}, 8'h01);
    finish_run();
  end
endmodule